// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Security Attributes

The block collects 109 level-sensitive interrupt lines and selects one of them for the processor. Software sets it up through a 32-bit register port. The port has a write strobe and a read strobe in the same cycle as the address, and read data is returned combinationally. Each source carries an enable bit, a secure/non-secure attribute bit and an 8-bit priority value. A global control word holds the master enable and two non-secure permission bits. An 8-bit threshold masks out every source that is not urgent enough.

The interrupt lines are sampled into a raw pending register each cycle. Arbitration compares every source that is pending, enabled and below the threshold while the master enable is set. The smallest priority value wins, and on a tie the smaller source number wins. The winner is reported as a one-hot bitmap, both on a port and in a readable window. The processor interrupt line stays high while any source qualifies.

Enables cannot be written directly. Software changes them through a write-one-to-set window and a write-one-to-clear window, so one store cannot undo an enable that another agent set. A typical bring-up writes the following, in this order:
1. Every source's attribute bit set to 1 (non-secure).
2. Every clear-enable bit written.
3. A threshold of 0x1F.
4. The control word with bits 0, 16 and 31 set together.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all stored state is zero. This covers control, threshold, attribute, enable and priority state, so `irq_o` is low and `hipend_o` is all zero.
- R2: The control word at byte offset 0x000 stores only bit 0 (master enable), bit 16 (non-secure enable) and bit 31 (non-secure enable mask); all other bits read as 0.
- R3: The threshold register at offset 0x00C stores write data bits 7:0 and reads them back in bits 7:0, with zeros above.
- R4: Attribute words at 0x080 + 4*w hold source 32*w+b in bit b, where 1 means non-secure. They are readable and writable.
- R5: Writing a word at 0x100 + 4*w sets the enable of source 32*w+b for every 1 in bit b. A 0 bit leaves the enable unchanged. Reading this window returns the enable bits.
- R6: Writing a word at 0x180 + 4*w clears the enable of source 32*w+b for every 1 in bit b. A 0 bit leaves it unchanged. Reading this window also returns the enable bits.
- R7: Priority words at 0x400 + 4*w hold the priority of source 4*w+k in bits 8*k+7:8*k. They are readable and writable, and 0xFF is the least urgent value.
- R8: Words at 0xD00 + 4*w return in bit b the level that source 32*w+b had on the clock edge before. Writes to this window change nothing.
- R9: A source is eligible only when it is pending, its enable is set, the master enable is set and its priority value is strictly below the threshold.
- R10: Among eligible sources the lowest priority value wins, and ties go to the lowest source number. The winner is the only bit set in `hipend_o` and in the words at 0xD80 + 4*w, which use the same bit layout as R8.
- R11: `irq_o` is high exactly when at least one source is eligible, in the same cycle that `hipend_o` shows a winner.
- R12: Some addresses read as 0 and ignore writes: unmapped offsets, misaligned offsets, and bit positions for source numbers 109 and above in the last word of every array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, data taken at the clock edge |
| bus_rd_i | input | 1 | Read strobe, data valid in the same cycle |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when no read is strobed |
| src_i | input | 109 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Processor interrupt request |
| hipend_o | output | 109 | One-hot winning source |

## Verification
A corrupted enable, priority or threshold bit does not stay hidden. It moves `hipend_o` and `irq_o` in the very cycle the bad state is registered. It also shows at the next read of the matching window, because every stored field reads back through the port. A pending flop that lags or sticks shows one edge after the line changes, both in the pending window and in the winner bitmap. Random source levels, enable churn and priority rewrites are run against a bench model of the rules. Directed cases are added for ties, values equal to the threshold, the master enable and the out-of-range bits of the last word.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned PRIO_W        = 8;
  localparam int unsigned PRIO_PER_WORD = WORD_W / PRIO_W;
  localparam int unsigned ADDR_W        = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_THR    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_ATTR   = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_ENSET  = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_ENCLR  = 12'h180;
  localparam logic [ADDR_W-1:0] OFF_PRIO   = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 12'hD00;
  localparam logic [ADDR_W-1:0] OFF_HIPEND = 12'hD80;

  localparam int unsigned CTRL_GEN_BIT = 0;
  localparam int unsigned CTRL_NS_BIT  = 16;
  localparam int unsigned CTRL_NSM_BIT = 31;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h8001_0001;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 109
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC-1:0]        hipend_i,
  output logic [WORD_W-1:0]       rdata_o,
  output logic [N_SRC-1:0]        en_o,
  output logic                    gen_o,
  output logic [PRIO_W-1:0]       thr_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o
);
  localparam int unsigned NW  = (N_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned NPW = (N_SRC + PRIO_PER_WORD - 1) / PRIO_PER_WORD;
  localparam int unsigned WIW = (NW > 1) ? $clog2(NW) : 1;
  localparam int unsigned PIW = (NPW > 1) ? $clog2(NPW) : 1;

  logic [ADDR_W-1:0] attr_off, set_off, clr_off, prio_off, pend_off, hip_off;
  logic ctrl_hit, thr_hit, attr_hit, set_hit, clr_hit, prio_hit, pend_hit, hip_hit;

  assign attr_off = addr_i - OFF_ATTR;
  assign set_off  = addr_i - OFF_ENSET;
  assign clr_off  = addr_i - OFF_ENCLR;
  assign prio_off = addr_i - OFF_PRIO;
  assign pend_off = addr_i - OFF_PEND;
  assign hip_off  = addr_i - OFF_HIPEND;

  // offset below base wraps high, so one compare covers both range ends
  assign ctrl_hit = (addr_i == OFF_CTRL);
  assign thr_hit  = (addr_i == OFF_THR);
  assign attr_hit = (attr_off[1:0] == 2'b0) && (attr_off[ADDR_W-1:2] < 10'(NW));
  assign set_hit  = (set_off[1:0]  == 2'b0) && (set_off[ADDR_W-1:2]  < 10'(NW));
  assign clr_hit  = (clr_off[1:0]  == 2'b0) && (clr_off[ADDR_W-1:2]  < 10'(NW));
  assign prio_hit = (prio_off[1:0] == 2'b0) && (prio_off[ADDR_W-1:2] < 10'(NPW));
  assign pend_hit = (pend_off[1:0] == 2'b0) && (pend_off[ADDR_W-1:2] < 10'(NW));
  assign hip_hit  = (hip_off[1:0]  == 2'b0) && (hip_off[ADDR_W-1:2]  < 10'(NW));

  logic gen_q, ns_q, nsm_q;
  logic [PRIO_W-1:0] thr_q;
  logic [N_SRC-1:0] attr_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= 1'b0;
      ns_q  <= 1'b0;
      nsm_q <= 1'b0;
      thr_q <= '0;
    end else if (wr_en_i) begin
      if (ctrl_hit) begin
        gen_q <= wdata_i[CTRL_GEN_BIT];
        ns_q  <= wdata_i[CTRL_NS_BIT];
        nsm_q <= wdata_i[CTRL_NSM_BIT];
      end
      if (thr_hit) thr_q <= wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam logic [9:0] WSEL = 10'(g / WORD_W);
    localparam logic [9:0] PSEL = 10'(g / PRIO_PER_WORD);
    localparam int unsigned BIT = g % WORD_W;
    localparam int unsigned LSB = (g % PRIO_PER_WORD) * PRIO_W;
    logic attr_r, en_r;
    logic [PRIO_W-1:0] prio_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        attr_r <= 1'b0;
        en_r   <= 1'b0;
        prio_r <= '0;
      end else if (wr_en_i) begin
        if (attr_hit && attr_off[ADDR_W-1:2] == WSEL) attr_r <= wdata_i[BIT];
        if (set_hit && set_off[ADDR_W-1:2] == WSEL && wdata_i[BIT]) en_r <= 1'b1;
        if (clr_hit && clr_off[ADDR_W-1:2] == WSEL && wdata_i[BIT]) en_r <= 1'b0;
        if (prio_hit && prio_off[ADDR_W-1:2] == PSEL) prio_r <= wdata_i[LSB +: PRIO_W];
      end
    end

    assign attr_q[g] = attr_r;
    assign en_q[g]   = en_r;
    assign prio_o[g*PRIO_W +: PRIO_W] = prio_r;
  end

  assign en_o  = en_q;
  assign gen_o = gen_q;
  assign thr_o = thr_q;

  // zero-padded word views for readback
  logic [NW*WORD_W-1:0]  attr_pad, en_pad, pend_pad, hip_pad;
  logic [NPW*WORD_W-1:0] prio_pad;
  logic [NW-1:0][WORD_W-1:0]  attr_w, en_w, pend_w, hip_w;
  logic [NPW-1:0][WORD_W-1:0] prio_w;

  always_comb begin
    attr_pad = '0; attr_pad[N_SRC-1:0] = attr_q;
    en_pad   = '0; en_pad[N_SRC-1:0]   = en_q;
    pend_pad = '0; pend_pad[N_SRC-1:0] = pend_i;
    hip_pad  = '0; hip_pad[N_SRC-1:0]  = hipend_i;
    prio_pad = '0; prio_pad[N_SRC*PRIO_W-1:0] = prio_o;
  end

  assign attr_w = attr_pad;
  assign en_w   = en_pad;
  assign pend_w = pend_pad;
  assign hip_w  = hip_pad;
  assign prio_w = prio_pad;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (ctrl_hit) begin
        rdata_o[CTRL_GEN_BIT] = gen_q;
        rdata_o[CTRL_NS_BIT]  = ns_q;
        rdata_o[CTRL_NSM_BIT] = nsm_q;
      end
      else if (thr_hit)  rdata_o = WORD_W'(thr_q);
      else if (attr_hit) rdata_o = attr_w[attr_off[WIW+1:2]];
      else if (set_hit)  rdata_o = en_w[set_off[WIW+1:2]];
      else if (clr_hit)  rdata_o = en_w[clr_off[WIW+1:2]];
      else if (prio_hit) rdata_o = prio_w[prio_off[PIW+1:2]];
      else if (pend_hit) rdata_o = pend_w[pend_off[WIW+1:2]];
      else if (hip_hit)  rdata_o = hip_w[hip_off[WIW+1:2]];
    end
  end

  assert_set_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && set_hit) |=> ((en_q & $past(en_q)) == $past(en_q)));
  assert_clr_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clr_hit) |=> ((en_q & ~$past(en_q)) == '0));
  assert_ctrl_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ctrl_hit) |-> ((rdata_o & ~CTRL_MASK) == '0));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 109
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC-1:0]        en_i,
  input  logic                    gen_i,
  input  logic [PRIO_W-1:0]       thr_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic [N_SRC-1:0]        hipend_o,
  output logic                    any_o
);
  localparam int unsigned IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned LEAVES = 1 << IW;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [N_SRC-1:0] elig;
  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IW-1:0]     ni [NODES];

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < N_SRC) begin : g_real
      assign elig[g] = pend_i[g] && en_i[g] && gen_i && (prio_i[g*PRIO_W +: PRIO_W] < thr_i);
      assign nv[LEAVES-1+g] = elig[g];
      assign np[LEAVES-1+g] = prio_i[g*PRIO_W +: PRIO_W];
      assign ni[LEAVES-1+g] = IW'(g);
    end else begin : g_pad
      assign nv[LEAVES-1+g] = 1'b0;
      assign np[LEAVES-1+g] = '1;
      assign ni[LEAVES-1+g] = IW'(g);
    end
  end

  // left child covers lower numbers, so <= keeps the lower number on ties
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_l;
    assign take_l = nv[2*k+1] && (!nv[2*k+2] || (np[2*k+1] <= np[2*k+2]));
    assign nv[k] = nv[2*k+1] || nv[2*k+2];
    assign np[k] = take_l ? np[2*k+1] : np[2*k+2];
    assign ni[k] = take_l ? ni[2*k+1] : ni[2*k+2];
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_hot
    assign hipend_o[g] = nv[0] && (ni[0] == IW'(g));
  end

  assign any_o = |elig;

  assert_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hipend_o));
  assert_irq_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o == (hipend_o != '0));
  assert_winner_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hipend_o & ~(pend_i & en_i)) == '0) && (gen_i || hipend_o == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 109
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o,
  output logic [N_SRC-1:0]  hipend_o
);
  logic [N_SRC-1:0]        pend_q, en, hip;
  logic                    gen, any;
  logic [PRIO_W-1:0]       thr;
  logic [N_SRC*PRIO_W-1:0] prio;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= src_i;
  end

  irqc_regs #(.N_SRC(N_SRC)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (bus_wr_i),
    .rd_en_i  (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .pend_i   (pend_q),
    .hipend_i (hip),
    .rdata_o  (bus_rdata_o),
    .en_o     (en),
    .gen_o    (gen),
    .thr_o    (thr),
    .prio_o   (prio)
  );

  irqc_arb #(.N_SRC(N_SRC)) arb_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_q),
    .en_i     (en),
    .gen_i    (gen),
    .thr_i    (thr),
    .prio_i   (prio),
    .hipend_o (hip),
    .any_o    (any)
  );

  assign irq_o    = any;
  assign hipend_o = hip;

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int N = 109;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] src = '0, hip;
  logic irq;

  always #5ns clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src), .irq_o(irq), .hipend_o(hip)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [N-1:0] m_en = '0, m_attr = '0;
  logic [7:0] m_prio [N];
  logic [7:0] m_thr = '0;
  logic m_gen = 1'b0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_bus(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_bus(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1ns; d = rdata; rd = 1'b0;
  endtask

  function automatic logic [31:0] word_of(logic [N-1:0] v, int w);
    logic [127:0] p;
    p = 128'(v);
    return 32'(p >> (w * 32));
  endfunction

  function automatic logic [31:0] prio_word(int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (4 * w + b < N) r = r | (32'(m_prio[4 * w + b]) << (8 * b));
    return r;
  endfunction

  function automatic logic [N-1:0] exp_win();
    int best = 256;
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (src[7'(i)] && m_en[7'(i)] && m_gen && int'(m_prio[i]) < int'(m_thr) && int'(m_prio[i]) < best)
        best = int'(m_prio[i]);
    for (int i = 0; i < N; i++)
      if (src[7'(i)] && m_en[7'(i)] && m_gen && int'(m_prio[i]) == best && r == '0)
        r[7'(i)] = 1'b1;
    return r;
  endfunction

  task automatic set_en(int w, logic [31:0] d);
    wr_bus(12'h100 + 12'(w * 4), d);
    for (int b = 0; b < 32; b++)
      if (d[5'(b)] && 32 * w + b < N) m_en[7'(32 * w + b)] = 1'b1;
  endtask

  task automatic clr_en(int w, logic [31:0] d);
    wr_bus(12'h180 + 12'(w * 4), d);
    for (int b = 0; b < 32; b++)
      if (d[5'(b)] && 32 * w + b < N) m_en[7'(32 * w + b)] = 1'b0;
  endtask

  task automatic wr_prio(int w, logic [31:0] d);
    wr_bus(12'h400 + 12'(w * 4), d);
    for (int b = 0; b < 4; b++)
      if (4 * w + b < N) m_prio[4 * w + b] = 8'(d >> (8 * b));
  endtask

  task automatic set_one_prio(int idx, logic [7:0] v);
    logic [31:0] d;
    m_prio[idx] = v;
    d = prio_word(idx / 4);
    wr_prio(idx / 4, d);
  endtask

  task automatic wr_ctrl(logic [31:0] d);
    wr_bus(12'h000, d);
    m_gen = d[0];
  endtask

  task automatic wr_thr(logic [7:0] t);
    wr_bus(12'h00C, 32'(t));
    m_thr = t;
  endtask

  task automatic check_all(string tag);
    logic [N-1:0] e;
    logic [31:0] d;
    @(negedge clk);
    e = exp_win();
    chk({"R10 bitmap ", tag}, 128'(hip), 128'(e));
    chk({"R11 irq ", tag}, 128'(irq), 128'(e != '0));
    for (int w = 0; w < 4; w++) begin
      rd_bus(12'hD80 + 12'(w * 4), d);
      chk({"R10 window ", tag}, 128'(d), 128'(word_of(e, w)));
      rd_bus(12'hD00 + 12'(w * 4), d);
      chk({"R8 pending ", tag}, 128'(d), 128'(word_of(src, w)));
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_prio[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", 128'(irq), 128'(0));
    chk("R1 bitmap", 128'(hip), 128'(0));
    rd_bus(12'h000, d); chk("R1 ctrl", 128'(d), 128'(0));
    rd_bus(12'h00C, d); chk("R1 thr", 128'(d), 128'(0));
    rd_bus(12'h100, d); chk("R1 enable", 128'(d), 128'(0));
    rd_bus(12'h400, d); chk("R1 prio", 128'(d), 128'(0));

    // bring-up sequence
    for (int w = 0; w < 4; w++) wr_bus(12'h080 + 12'(w * 4), 32'hFFFF_FFFF);
    m_attr = '1;
    for (int w = 0; w < 4; w++) clr_en(w, 32'hFFFF_FFFF);
    wr_thr(8'h1F);
    wr_ctrl(32'h8001_0001);

    for (int w = 0; w < 4; w++) begin
      rd_bus(12'h080 + 12'(w * 4), d);
      chk("R4 R12 attr readback", 128'(d), 128'(word_of(m_attr, w)));
    end
    rd_bus(12'h00C, d); chk("R3 thr", 128'(d), 128'(32'h1F));
    rd_bus(12'h000, d); chk("R2 ctrl", 128'(d), 128'(32'h8001_0001));
    wr_ctrl(32'hFFFF_FFFF);
    rd_bus(12'h000, d); chk("R2 ctrl reserved", 128'(d), 128'(32'h8001_0001));
    wr_ctrl(32'h0000_0000);
    rd_bus(12'h000, d); chk("R2 ctrl clear", 128'(d), 128'(0));
    wr_ctrl(32'h8001_0001);
    wr_bus(12'h00C, 32'hABCD_EF42); m_thr = 8'h42;
    rd_bus(12'h00C, d); chk("R3 thr upper", 128'(d), 128'(32'h42));
    wr_thr(8'h1F);

    d = $urandom;
    wr_bus(12'h084, d);
    for (int b = 0; b < 32; b++) m_attr[7'(32 + b)] = d[5'(b)];
    rd_bus(12'h084, r); chk("R4 attr word1", 128'(r), 128'(d));

    // priorities
    for (int w = 0; w < 28; w++) wr_prio(w, $urandom);
    rd_bus(12'h400, d); chk("R7 prio w0", 128'(d), 128'(prio_word(0)));
    rd_bus(12'h434, d); chk("R7 prio w13", 128'(d), 128'(prio_word(13)));
    rd_bus(12'h46C, d); chk("R7 R12 prio w27", 128'(d), 128'(prio_word(27)));
    rd_bus(12'h470, d); chk("R12 past prio", 128'(d), 128'(0));

    // enables
    for (int w = 0; w < 4; w++) set_en(w, $urandom);
    for (int w = 0; w < 4; w++) begin
      rd_bus(12'h100 + 12'(w * 4), d); chk("R5 set window", 128'(d), 128'(word_of(m_en, w)));
      rd_bus(12'h180 + 12'(w * 4), d); chk("R6 clr window", 128'(d), 128'(word_of(m_en, w)));
    end
    set_en(1, 32'h0); clr_en(2, 32'h0);
    rd_bus(12'h104, d); chk("R5 zero write", 128'(d), 128'(word_of(m_en, 1)));
    rd_bus(12'h188, d); chk("R6 zero write", 128'(d), 128'(word_of(m_en, 2)));
    clr_en(0, $urandom);
    rd_bus(12'h180, d); chk("R6 clear", 128'(d), 128'(word_of(m_en, 0)));

    // R12 out-of-range, unmapped and misaligned
    set_en(3, 32'hFFFF_E000);
    rd_bus(12'h10C, d); chk("R12 last word", 128'(d), 128'(word_of(m_en, 3)));
    rd_bus(12'h010, d); chk("R12 unmapped", 128'(d), 128'(0));
    rd_bus(12'h202, d); chk("R12 unmapped 2", 128'(d), 128'(0));
    rd_bus(12'h101, d); chk("R12 misaligned", 128'(d), 128'(0));
    wr_bus(12'h001, 32'h0);
    rd_bus(12'h000, d); chk("R12 misaligned write", 128'(d), 128'(32'h8001_0001));

    // R8 pending, writes ignored
    @(negedge clk); src = {$urandom, $urandom, $urandom, $urandom};
    check_all("initial");
    wr_bus(12'hD00, 32'h0); wr_bus(12'hD80, 32'hFFFF_FFFF);
    check_all("pend write ignored");

    // random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 5))
        0: begin @(negedge clk); src = {$urandom, $urandom, $urandom, $urandom}; end
        1: set_en($urandom_range(0, 3), $urandom);
        2: clr_en($urandom_range(0, 3), $urandom);
        3: wr_prio($urandom_range(0, 27), $urandom);
        4: wr_thr(($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom));
        default: wr_ctrl(($urandom_range(0, 4) == 0) ? 32'h0 : 32'h8001_0001);
      endcase
      check_all("random");
    end

    // directed: tie, threshold edge, master enable, top source
    wr_ctrl(32'h8001_0001);
    for (int w = 0; w < 4; w++) clr_en(w, 32'hFFFF_FFFF);
    @(negedge clk); src = '0; src[5] = 1'b1; src[40] = 1'b1; src[108] = 1'b1;
    set_one_prio(5, 8'h03); set_one_prio(40, 8'h03); set_one_prio(108, 8'h03);
    set_en(0, 32'h20); set_en(1, 32'h100); set_en(3, 32'h1000);
    wr_thr(8'h10);
    check_all("R10 tie");
    chk("R10 tie lowest", 128'(hip), 128'(1) << 5);
    set_one_prio(40, 8'h02);
    check_all("R10 lower value");
    chk("R10 lower value wins", 128'(hip), 128'(1) << 40);
    wr_thr(8'h02);
    check_all("R9 equal thr");
    chk("R9 equal thr blocks", 128'(irq), 128'(0));
    wr_thr(8'h20); wr_ctrl(32'h0001_0000);
    check_all("R9 master off");
    chk("R9 master off quiet", 128'(irq), 128'(0));
    wr_ctrl(32'h8001_0001);
    clr_en(0, 32'h20); clr_en(1, 32'h100); set_one_prio(108, 8'h00);
    check_all("R10 top source");
    chk("R10 top source wins", 128'(hip), 128'(1) << 108);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule